// File: doc/BRIEF.md
# Flash read DMA engine

This block copies a contiguous range of serial flash into system memory without processor involvement. Software writes a flash source address, a destination start address and an exclusive destination end address, chooses how the read is sent on the serial bus, then sets a start bit. The engine opens a flash transaction, sends a read opcode, the address and any dummy clocks, and shifts in data on one, two or four lines. It packs the incoming bytes into 32-bit words and hands each word to a valid/ready write port at rising destination addresses.

The start bit doubles as the busy flag. It stays set for the whole copy and clears itself only once the memory port has accepted the last word. The number of bytes copied is the end address minus the start address. All three addresses are 16-byte aligned, and the hardware discards their low four bits. The serial clock runs at half the system clock in SPI mode 0: the flash samples on the rising edge and the engine samples on the falling edge.

Top module: `flash_rd_dma`

## Requirements
- R1: After reset, every readable register reads 0, `spi_cs_n` is 1, `spi_sck` is 0 and `mem_valid` is 0. Whenever `spi_cs_n` is 1, `spi_sck` is 0.
- R2: Writing 1 to bit 0 of register select 0 (control) sets that bit. It reads 1 while the copy runs and returns to 0 by itself when the copy ends.
- R3: Register selects 1 (flash source), 2 (destination start) and 3 (destination end) store the written value with bits 3:0 forced to zero.
- R4: The copy length in bytes is end minus start. When end is not above start, the control bit clears within a few cycles, no flash transaction opens and no memory write is issued.
- R5: The opcode is sent first, MSB first, on `spi_io_o[0]`. Its source depends on register select 4 (bus mode) and register select 5 (bit 0: fast). If bus bit 2 is set, the opcode comes from register select 7. Otherwise, if bus bit 0 is set, it comes from register select 6. Otherwise it is 0x0B when fast is set and 0x03 when it is not.
- R6: The address follows the opcode, most significant bit first. Bus bit 4 selects 4 bytes (the full source); otherwise 3 bytes are sent (source bits 23:0). The address uses four lines if bus bit 3 is set, otherwise two lines if bus bit 1 is set, otherwise one line (`spi_io_o[0]`). The highest-numbered line carries the most significant bit.
- R7: Eight dummy clocks follow the address, except in plain single-line read (bus bits 0 and 2 clear, fast clear), which has none.
- R8: Data is received on four lines `spi_io_i[3:0]` if bus bit 2 is set, otherwise on two lines `spi_io_i[1:0]` if bus bit 0 is set, otherwise on `spi_io_i[1]`. It arrives MSB first, with the higher line carrying the higher bit.
- R9: The byte read from flash offset k (counted from the source address) lands in bits 8*(k mod 4)+7 down to 8*(k mod 4) of the word written to destination start + 4*(k div 4). Words are written in ascending address order.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, address and data hold steady. The control bit clears only after the last word has been accepted.
- R11: While the control bit is set, writes to any register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 3 | Register select for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rsel | input | 3 | Register select for reads |
| reg_rdata | output | 32 | Registered read data, valid one cycle after `reg_rsel` |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_io_o | output | 4 | Serial data out |
| spi_io_oe | output | 4 | Per-line output enable |
| spi_io_i | input | 4 | Serial data in |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accept |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_data | output | 32 | Memory write word |

## Verification
A wrong phase length or line width in the serial sequencer first shows up at the flash pins: the responder decodes a different opcode or address from the very first transaction of that mode. When only the dummy count or the sample line is wrong, the bytes shift by a few bits, and the very first memory word of the copy already miscompares. A fault in the packer's lane or address counter corrupts the first word or its address. A completion fault, either a byte count that is off or a done signal that fires early, leaves the busy bit out of step with the number of accepted words. The bench sees this at the poll that finds the copy finished.

// File: rtl/flash_dma_pkg.sv
`timescale 1ns/1ps
package flash_dma_pkg;

  // register selects
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_DST  = 3'd2;
  localparam logic [2:0] SEL_END  = 3'd3;
  localparam logic [2:0] SEL_BUS  = 3'd4;
  localparam logic [2:0] SEL_FAST = 3'd5;
  localparam logic [2:0] SEL_OPC2 = 3'd6;
  localparam logic [2:0] SEL_OPC4 = 3'd7;

  // bus mode bit positions
  localparam int BUS_DAT2 = 0;
  localparam int BUS_ADR2 = 1;
  localparam int BUS_DAT4 = 2;
  localparam int BUS_ADR4 = 3;
  localparam int BUS_ADDR32 = 4;

  localparam logic [7:0] OPC_PLAIN = 8'h03;
  localparam logic [7:0] OPC_FAST  = 8'h0B;

  localparam int SLOT_W = 6;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CMD, SQ_ADR, SQ_DMY, SQ_DAT, SQ_BYT, SQ_FIN
  } sq_state_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic       addr32;
    logic [2:0] adr_w;   // lines: 1, 2 or 4
    logic [2:0] dat_w;   // lines: 1, 2 or 4
    logic       dummy;
  } rd_mode_t;

  function automatic logic [SLOT_W-1:0] adr_slots(input logic [2:0] w, input logic a32);
    case (w)
      3'd4:    return a32 ? 6'd8  : 6'd6;
      3'd2:    return a32 ? 6'd16 : 6'd12;
      default: return a32 ? 6'd32 : 6'd24;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] dat_slots(input logic [2:0] w);
    case (w)
      3'd4:    return 6'd2;
      3'd2:    return 6'd4;
      default: return 6'd8;
    endcase
  endfunction

endpackage

// File: rtl/fdma_regs.sv
`timescale 1ns/1ps
module fdma_regs
  import flash_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wsel,
  input  logic [31:0]   wdata,
  input  logic [2:0]    rsel,
  input  logic          done,
  output logic [31:0]   rdata,
  output logic          busy,
  output logic          go,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [AW-1:0] end_q,
  output logic [4:0]    bus_q,
  output logic          fast_q,
  output logic [7:0]    opc2_q,
  output logic [7:0]    opc4_q
);

  localparam int ALIGN_B = 4;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      go     <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      end_q  <= '0;
      bus_q  <= '0;
      fast_q <= 1'b0;
      opc2_q <= '0;
      opc4_q <= '0;
    end else begin
      go <= 1'b0;
      if (done) busy <= 1'b0;
      if (wr_en && !busy) begin
        case (wsel)
          SEL_CTRL: if (wdata[0]) begin busy <= 1'b1; go <= 1'b1; end
          SEL_SRC:  src_q  <= {wdata[AW-1:ALIGN_B], {ALIGN_B{1'b0}}};
          SEL_DST:  dst_q  <= {wdata[AW-1:ALIGN_B], {ALIGN_B{1'b0}}};
          SEL_END:  end_q  <= {wdata[AW-1:ALIGN_B], {ALIGN_B{1'b0}}};
          SEL_BUS:  bus_q  <= wdata[4:0];
          SEL_FAST: fast_q <= wdata[0];
          SEL_OPC2: opc2_q <= wdata[7:0];
          default:  opc4_q <= wdata[7:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (rsel)
        SEL_CTRL: rdata <= {31'b0, busy};
        SEL_SRC:  rdata <= src_q;
        SEL_DST:  rdata <= dst_q;
        SEL_END:  rdata <= end_q;
        SEL_BUS:  rdata <= {27'b0, bus_q};
        SEL_FAST: rdata <= {31'b0, fast_q};
        SEL_OPC2: rdata <= {24'b0, opc2_q};
        default:  rdata <= {24'b0, opc4_q};
      endcase
    end
  end

  // R2
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(src_q) && $stable(dst_q) && $stable(end_q) && $stable(bus_q)));

endmodule

// File: rtl/fdma_spi_seq.sv
`timescale 1ns/1ps
module fdma_spi_seq
  import flash_dma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DUMMY_SLOTS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  rd_mode_t      mode,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] nbytes,
  input  logic [3:0]    io_i,
  input  logic          byte_ready,
  output logic          sck,
  output logic          cs_n,
  output logic [3:0]    io_o,
  output logic [3:0]    io_oe,
  output logic          byte_valid,
  output logic [7:0]    byte_data,
  output logic          done
);

  sq_state_e         state;
  logic              hi;
  logic [31:0]       tx_sh;
  logic [SLOT_W-1:0] slots;
  logic [7:0]        rx_sh;
  logic [AW-1:0]     left;
  logic [2:0]        cur_w;
  logic [7:0]        rx_next;

  always_comb begin
    case (state)
      SQ_ADR:  cur_w = mode.adr_w;
      SQ_DAT:  cur_w = mode.dat_w;
      default: cur_w = 3'd1;
    endcase
  end

  always_comb begin
    case (mode.dat_w)
      3'd4:    rx_next = {rx_sh[3:0], io_i};
      3'd2:    rx_next = {rx_sh[5:0], io_i[1:0]};
      default: rx_next = {rx_sh[6:0], io_i[1]};
    endcase
  end

  always_comb begin
    io_o  = 4'b0;
    io_oe = 4'b0;
    if (state == SQ_CMD || state == SQ_ADR) begin
      case (cur_w)
        3'd4:    begin io_o = tx_sh[31:28];          io_oe = 4'b1111; end
        3'd2:    begin io_o = {2'b0, tx_sh[31:30]};  io_oe = 4'b0011; end
        default: begin io_o = {3'b0, tx_sh[31]};     io_oe = 4'b0001; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      hi         <= 1'b0;
      sck        <= 1'b0;
      cs_n       <= 1'b1;
      tx_sh      <= '0;
      slots      <= '0;
      rx_sh      <= '0;
      left       <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (go) begin
            cs_n  <= 1'b0;
            state <= SQ_CMD;
            tx_sh <= {mode.opcode, 24'b0};
            slots <= SLOT_W'(8);
            hi    <= 1'b0;
            left  <= nbytes;
          end
        end
        SQ_CMD, SQ_ADR, SQ_DMY, SQ_DAT: begin
          if (!hi) begin
            sck <= 1'b1;
            hi  <= 1'b1;
          end else begin
            sck   <= 1'b0;
            hi    <= 1'b0;
            tx_sh <= tx_sh << cur_w;
            slots <= slots - 1'b1;
            if (state == SQ_DAT) rx_sh <= rx_next;
            if (slots == SLOT_W'(1)) begin
              case (state)
                SQ_CMD: begin
                  state <= SQ_ADR;
                  tx_sh <= mode.addr32 ? src[31:0] : {src[23:0], 8'h00};
                  slots <= adr_slots(mode.adr_w, mode.addr32);
                end
                SQ_ADR: begin
                  if (mode.dummy) begin
                    state <= SQ_DMY;
                    slots <= SLOT_W'(DUMMY_SLOTS);
                  end else begin
                    state <= SQ_DAT;
                    slots <= dat_slots(mode.dat_w);
                  end
                end
                SQ_DMY: begin
                  state <= SQ_DAT;
                  slots <= dat_slots(mode.dat_w);
                end
                default: begin
                  state      <= SQ_BYT;
                  byte_valid <= 1'b1;
                  byte_data  <= rx_next;
                end
              endcase
            end
          end
        end
        SQ_BYT: begin
          if (byte_ready) begin
            byte_valid <= 1'b0;
            if (left == AW'(1)) begin
              state <= SQ_FIN;
              cs_n  <= 1'b1;
            end else begin
              left  <= left - 1'b1;
              state <= SQ_DAT;
              slots <= dat_slots(mode.dat_w);
            end
          end
        end
        default: begin
          done  <= 1'b1;
          state <= SQ_IDLE;
        end
      endcase
    end
  end

  // R1
  idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  // R9
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  // R4
  cs_open_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(go));

endmodule

// File: rtl/fdma_packer.sv
`timescale 1ns/1ps
module fdma_packer #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          byte_ready,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_data,
  output logic          idle
);

  localparam int LANES = 4;
  localparam int LW    = $clog2(LANES);

  logic [23:0]   asm_q;
  logic [LW-1:0] lane;
  logic [AW-1:0] nxt_addr;
  logic          take;

  assign byte_ready = (lane != LW'(LANES-1)) || !mem_valid || mem_ready;
  assign take       = byte_valid && byte_ready;
  assign idle       = !mem_valid && (lane == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      asm_q     <= '0;
      lane      <= '0;
      nxt_addr  <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      if (mem_valid && mem_ready) mem_valid <= 1'b0;
      if (load) begin
        nxt_addr <= base;
        lane     <= '0;
      end else if (take) begin
        lane <= lane + 1'b1;
        case (lane)
          2'd0: asm_q[7:0]   <= byte_data;
          2'd1: asm_q[15:8]  <= byte_data;
          2'd2: asm_q[23:16] <= byte_data;
          default: begin
            mem_data  <= {byte_data, asm_q};
            mem_addr  <= nxt_addr;
            mem_valid <= 1'b1;
            nxt_addr  <= nxt_addr + AW'(LANES);
          end
        endcase
      end
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data) && $stable(mem_addr)));

endmodule

// File: rtl/flash_rd_dma.sv
`timescale 1ns/1ps
module flash_rd_dma
  import flash_dma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DUMMY_SLOTS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_wsel,
  input  logic [31:0]   reg_wdata,
  input  logic [2:0]    reg_rsel,
  output logic [31:0]   reg_rdata,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic [3:0]    spi_io_o,
  output logic [3:0]    spi_io_oe,
  input  logic [3:0]    spi_io_i,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_data
);

  logic          busy, go, done_q, seq_done, seq_over;
  logic [AW-1:0] src_q, dst_q, end_q, nbytes;
  logic [4:0]    bus_q;
  logic          fast_q;
  logic [7:0]    opc2_q, opc4_q;
  logic          empty_len, seq_go;
  logic          bvalid, bready, pk_idle;
  logic [7:0]    bdata;
  rd_mode_t      mode;

  fdma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wsel(reg_wsel), .wdata(reg_wdata),
    .rsel(reg_rsel), .done(done_q), .rdata(reg_rdata), .busy(busy), .go(go),
    .src_q(src_q), .dst_q(dst_q), .end_q(end_q), .bus_q(bus_q), .fast_q(fast_q),
    .opc2_q(opc2_q), .opc4_q(opc4_q)
  );

  always_comb begin
    mode.addr32 = bus_q[BUS_ADDR32];
    if (bus_q[BUS_DAT4]) begin
      mode.opcode = opc4_q;
      mode.dat_w  = 3'd4;
    end else if (bus_q[BUS_DAT2]) begin
      mode.opcode = opc2_q;
      mode.dat_w  = 3'd2;
    end else begin
      mode.opcode = fast_q ? OPC_FAST : OPC_PLAIN;
      mode.dat_w  = 3'd1;
    end
    mode.dummy = bus_q[BUS_DAT4] || bus_q[BUS_DAT2] || fast_q;
    if (bus_q[BUS_ADR4])      mode.adr_w = 3'd4;
    else if (bus_q[BUS_ADR2]) mode.adr_w = 3'd2;
    else                      mode.adr_w = 3'd1;
  end

  assign nbytes    = end_q - dst_q;
  assign empty_len = (end_q <= dst_q);
  assign seq_go    = go && !empty_len;

  fdma_spi_seq #(.AW(AW), .DUMMY_SLOTS(DUMMY_SLOTS)) u_seq (
    .clk(clk), .rst(rst), .go(seq_go), .mode(mode), .src(src_q), .nbytes(nbytes),
    .io_i(spi_io_i), .byte_ready(bready), .sck(spi_sck), .cs_n(spi_cs_n),
    .io_o(spi_io_o), .io_oe(spi_io_oe), .byte_valid(bvalid), .byte_data(bdata),
    .done(seq_done)
  );

  fdma_packer #(.AW(AW)) u_pack (
    .clk(clk), .rst(rst), .load(go), .base(dst_q), .byte_valid(bvalid),
    .byte_data(bdata), .byte_ready(bready), .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .idle(pk_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      seq_over <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (seq_done) seq_over <= 1'b1;
      if (go && empty_len) done_q <= 1'b1;
      if (seq_over && pk_idle && !done_q) begin
        done_q   <= 1'b1;
        seq_over <= 1'b0;
      end
    end
  end

  // R10
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy);

endmodule

// File: tb/flash_rd_dma_bench.sv
`timescale 1ns/1ps
module flash_rd_dma_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_wsel = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_rsel = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n;
  logic [3:0]  spi_io_o, spi_io_oe;
  logic [3:0]  fl_io = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_data;

  always #10 clk = ~clk;

  flash_rd_dma u_flash_rd_dma (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(fl_io),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;

  // expectations shared with responder and memory monitor
  logic [7:0]  exp_opc;
  int          exp_aw, exp_dw, exp_dmy;
  bit          exp_a32;
  logic [31:0] exp_faddr, exp_dst;
  int          wcount = 0;
  int          cs_falls = 0;
  int          rmode = 0;
  logic [7:0]  lfsr = 8'h5B;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
  endfunction

  // flash responder
  initial begin
    forever begin
      logic [7:0]  cmd;
      logic [31:0] a;
      logic [31:0] ptr;
      int          bp;
      logic [7:0]  cur;
      logic [3:0]  bits;
      @(negedge spi_cs_n);
      cs_falls++;
      cmd = '0;
      for (int i = 0; i < 8; i++) begin
        @(posedge spi_sck);
        cmd = {cmd[6:0], spi_io_o[0]};
      end
      check(cmd == exp_opc, "R5 opcode", {24'b0, cmd}, {24'b0, exp_opc});
      a = '0;
      for (int i = 0; i < (exp_a32 ? 32 : 24) / exp_aw; i++) begin
        @(posedge spi_sck);
        case (exp_aw)
          4:       a = (a << 4) | {28'b0, spi_io_o};
          2:       a = (a << 2) | {30'b0, spi_io_o[1:0]};
          default: a = (a << 1) | {31'b0, spi_io_o[0]};
        endcase
      end
      check(a == exp_faddr, "R6 address", a, exp_faddr);
      for (int i = 0; i < exp_dmy; i++) @(posedge spi_sck);
      ptr = a;
      bp  = 0;
      forever begin
        @(negedge spi_sck or posedge spi_cs_n);
        if (spi_cs_n) break;
        #2;
        cur  = fbyte(ptr);
        bits = 4'((cur >> (8 - exp_dw - bp)) & ((1 << exp_dw) - 1));
        case (exp_dw)
          4:       fl_io = bits;
          2:       fl_io = {2'b0, bits[1:0]};
          default: fl_io = {2'b0, bits[0], 1'b0};
        endcase
        bp = bp + exp_dw;
        if (bp == 8) begin
          bp  = 0;
          ptr = ptr + 1;
        end
      end
    end
  end

  // memory side: ready pattern and word checks
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rmode)
      0:       mem_ready = 1'b1;
      1:       mem_ready = ~mem_ready;
      default: mem_ready = lfsr[0] & lfsr[2];
    endcase
    if (!rst && mem_valid && mem_ready) begin
      logic [31:0] ew;
      logic [31:0] fa;
      fa = exp_faddr + 32'(4 * wcount);
      ew = {fbyte(fa + 3), fbyte(fa + 2), fbyte(fa + 1), fbyte(fa)};
      // R9 word address
      check(mem_addr == exp_dst + 32'(4 * wcount), "R9 word address", mem_addr, exp_dst + 32'(4 * wcount));
      // R7 R8 R9 word content
      check(mem_data == ew, "R8 word data", mem_data, ew);
      wcount++;
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wsel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_rsel = sel;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run(input int cfg, input logic [31:0] src, input logic [31:0] dst,
                     input int nb, input int rm);
    logic [4:0]  bus;
    bit          fast;
    logic [31:0] r, srca;
    int          polls;
    logic [7:0]  o2, o4;
    o2 = (cfg == 4) ? 8'hBB : 8'h3B;
    o4 = (cfg == 6) ? 8'hEB : 8'h6B;
    fast = 0;
    case (cfg)
      0: begin bus = 5'b00000; exp_opc = 8'h03; exp_dw = 1; exp_aw = 1; exp_a32 = 0; exp_dmy = 0; end
      1: begin bus = 5'b00000; fast = 1; exp_opc = 8'h0B; exp_dw = 1; exp_aw = 1; exp_a32 = 0; exp_dmy = 8; end
      2: begin bus = 5'b10000; exp_opc = 8'h03; exp_dw = 1; exp_aw = 1; exp_a32 = 1; exp_dmy = 0; end
      3: begin bus = 5'b00001; exp_opc = o2; exp_dw = 2; exp_aw = 1; exp_a32 = 0; exp_dmy = 8; end
      4: begin bus = 5'b00011; exp_opc = o2; exp_dw = 2; exp_aw = 2; exp_a32 = 0; exp_dmy = 8; end
      5: begin bus = 5'b00100; exp_opc = o4; exp_dw = 4; exp_aw = 1; exp_a32 = 0; exp_dmy = 8; end
      6: begin bus = 5'b11100; exp_opc = o4; exp_dw = 4; exp_aw = 4; exp_a32 = 1; exp_dmy = 8; end
      default: begin bus = 5'b00101; fast = 1; exp_opc = o4; exp_dw = 4; exp_aw = 1; exp_a32 = 0; exp_dmy = 8; end
    endcase
    srca      = src & 32'hFFFF_FFF0;
    exp_faddr = exp_a32 ? srca : {8'h00, srca[23:0]};
    exp_dst   = dst & 32'hFFFF_FFF0;
    rmode     = rm;
    wcount    = 0;
    wr(3'd6, {24'b0, o2});
    wr(3'd7, {24'b0, o4});
    wr(3'd4, {27'b0, bus});
    wr(3'd5, {31'b0, fast});
    wr(3'd1, src);
    wr(3'd2, dst);
    wr(3'd3, exp_dst + 32'(nb));
    // R3 stored with low bits cleared
    rd(3'd1, r);
    check(r == srca, "R3 source align", r, srca);
    rd(3'd2, r);
    check(r == exp_dst, "R3 dest align", r, exp_dst);
    wr(3'd0, 32'h1);
    rd(3'd0, r);
    check(r == 32'h1, "R2 busy while running", r, 32'h1);
    // R11 writes ignored while busy
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd4, 32'h0);
    rd(3'd1, r);
    check(r == srca, "R11 source held", r, srca);
    rd(3'd4, r);
    check(r == {27'b0, bus}, "R11 bus mode held", r, {27'b0, bus});
    polls = 0;
    do begin
      rd(3'd0, r);
      polls++;
    end while (r[0] && polls < 6000);
    check(r[0] == 1'b0, "R2 self clear", r, 32'h0);
    // R10 R4 all words accepted when busy drops
    check(wcount == nb / 4, "R10 words at completion", 32'(wcount), 32'(nb / 4));
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && !mem_valid, "R1 idle lines after copy",
          {29'b0, spi_cs_n, spi_sck, mem_valid}, 32'h4);
  endtask

  task automatic run_empty(input logic [31:0] dst, input logic [31:0] dend);
    logic [31:0] r;
    int c0;
    c0 = cs_falls;
    wcount = 0;
    wr(3'd2, dst);
    wr(3'd3, dend);
    wr(3'd0, 32'h1);
    repeat (6) @(negedge clk);
    rd(3'd0, r);
    check(r == 32'h0, "R4 empty copy clears", r, 32'h0);
    check(cs_falls == c0, "R4 no flash access", 32'(cs_falls), 32'(c0));
    check(wcount == 0, "R4 no memory write", 32'(wcount), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    exp_opc = 8'h03; exp_aw = 1; exp_dw = 1; exp_dmy = 0; exp_a32 = 0;
    exp_faddr = '0; exp_dst = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && !mem_valid, "R1 reset lines",
          {29'b0, spi_cs_n, spi_sck, mem_valid}, 32'h4);
    rst = 1'b0;
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), r);
      check(r == 32'h0, "R1 register reset", r, 32'h0);
    end
    // R3 alignment
    wr(3'd3, 32'h1234_567F);
    rd(3'd3, r);
    check(r == 32'h1234_5670, "R3 end align", r, 32'h1234_5670);
    // R4 empty and reversed ranges
    run_empty(32'h0000_0500, 32'h0000_0500);
    run_empty(32'h0000_0500, 32'h0000_0400);
    // R5 R6 R7 R8 mode sweep
    run(0, 32'h0000_0120, 32'h0000_1000, 16, 0);
    run(1, 32'h0000_3450, 32'h0000_2000, 48, 1);
    run(2, 32'h1234_5670, 32'h0000_3000, 32, 2);
    run(3, 32'h0000_0807, 32'h0000_4008, 48, 2);
    run(4, 32'h0000_ABC0, 32'h0000_5000, 32, 1);
    run(5, 32'h0001_0010, 32'h0000_6000, 48, 0);
    run(6, 32'h7F00_0F30, 32'h0000_7000, 64, 2);
    run(7, 32'h0000_0040, 32'h0000_8000, 16, 1);
    run(0, 32'hAB00_1230, 32'h0000_9000, 32, 2);
    run(6, 32'h0000_0200, 32'hFFFF_FF00, 32, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule